// File: doc/BRIEF.md
# Logical Shift-Right Instruction Sequencer

This block runs one logical shift-right instruction at a time, cycle by cycle, on an 8-bit data, 16-bit address synchronous memory bus. An issuing stage hands it an opcode byte together with the current X index value. The sequencer then fetches the operand bytes that follow the opcode and forms the effective address. For memory operands it runs a read-modify-write through a one-bit shift unit. At the end it updates the accumulator or the memory byte, sets the carry, zero and negative flags, and advances its program counter past the instruction. Instruction fetch, interrupts and every other instruction belong to other blocks.

The issue side is a valid/ready stream. `in_ready` is high only while the sequencer is idle. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high, and that cycle counts as the first cycle of the instruction. While the sequencer is busy, `in_ready` stays low and the issuer must hold off. `in_ready` returns in the cycle after `done`. The memory bus has no stall input: read data is sampled at the end of every cycle in which `mem_re` is high.

Top module: `lsr_seq_top`

## Requirements
- R1: `in_ready` is high exactly when the sequencer is idle. An issue is accepted when `in_valid` and `in_ready` are both high at a clock edge, and `in_ready` is low from the next cycle until `done` has been seen.
- R2: Counting the accept cycle as cycle 1, `done` is high for one cycle, in the last cycle of the instruction. The counts are: opcode 0x4A (accumulator) 2 cycles, 0x46 (zero page) 5, 0x56 (zero page + X) 6, 0x4E (absolute) 6, 0x5E (absolute + X) 7. Absolute + X never varies with page crossing.
- R3: After `done`, `pc` has advanced by the instruction length: 1 byte for 0x4A, 2 for 0x46 and 0x56, 3 for 0x4E and 0x5E.
- R4: Operand bytes are read at `pc+1`, and then at `pc+2` for 16-bit operands. The low address byte comes first.
- R5: Zero page + X uses address {0x00, (operand + X) mod 256}. Before the data read there is one dummy read at the unindexed zero-page address.
- R6: Absolute + X uses the full 16-bit sum base + X, carrying into the high byte. Before the data read there is one dummy read at {base high byte, low byte + X without carry}.
- R7: Memory modes end with three consecutive bus cycles at the effective address: a read of the old value, a write of the old value, and a write of the shifted value. The last write falls in the `done` cycle.
- R8: The shifted value is the operand moved one bit toward bit 0, with 0 entering bit 7. Mode 0x4A writes it to `acc`. Memory modes write it to memory and leave `acc` unchanged.
- R9: After `done`, `flag_c` equals bit 0 of the operand before the shift, `flag_z` is 1 exactly when the shifted value is zero, and `flag_n` is 0.
- R10: Any other opcode produces a one-cycle `err` pulse in the cycle after acceptance. It causes no bus cycle, leaves `pc`, `acc` and the flags unchanged, and `in_ready` stays high.
- R11: `acc_ld` writes `acc_ld_data` into `acc` only while idle, and is ignored while busy. When it coincides with the acceptance of 0x4A, the shift operates on the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue stream valid |
| in_ready | output | 1 | Issue stream ready (idle) |
| in_opcode | input | 8 | Opcode byte of the issued instruction |
| in_x | input | 8 | X index value, captured on accept |
| acc_ld | input | 1 | Accumulator preset strobe (idle only) |
| acc_ld_data | input | 8 | Accumulator preset value |
| mem_addr | output | 16 | Bus address |
| mem_re | output | 1 | Bus read strobe |
| mem_we | output | 1 | Bus write strobe |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, sampled at the end of a read cycle |
| done | output | 1 | Last cycle of the instruction |
| err | output | 1 | Unsupported opcode pulse |
| acc | output | 8 | Accumulator |
| pc | output | 16 | Program counter |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Two things can fall in one cycle: the accumulator preset strobe and the acceptance of an accumulator-mode instruction. The bench raises `acc_ld` in the very cycle it issues 0x4A. It then checks that the shifted result and the carry come from the preset value rather than from the older accumulator. The bench also keeps `acc_ld` raised throughout a memory-mode instruction, and checks afterwards that `acc` did not move.

// File: rtl/lsr_seq_pkg.sv
package lsr_seq_pkg;

  typedef enum logic [2:0] {
    AM_ACC,
    AM_ZP,
    AM_ZPX,
    AM_ABS,
    AM_ABX
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPLO,
    ST_OPHI,
    ST_IDX,
    ST_RD,
    ST_WOLD,
    ST_WNEW,
    ST_ACC
  } sstate_e;

  localparam logic [7:0] OPC_SHR_ACC = 8'h4A;
  localparam logic [7:0] OPC_SHR_ZP  = 8'h46;
  localparam logic [7:0] OPC_SHR_ZPX = 8'h56;
  localparam logic [7:0] OPC_SHR_ABS = 8'h4E;
  localparam logic [7:0] OPC_SHR_ABX = 8'h5E;

endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_seq_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             legal,
  output amode_e           mode,
  output logic [1:0]       len
);
  always_comb begin
    legal = 1'b1;
    mode  = AM_ACC;
    len   = 2'd1;
    unique case (opcode)
      OPC_SHR_ACC: begin mode = AM_ACC; len = 2'd1; end
      OPC_SHR_ZP:  begin mode = AM_ZP;  len = 2'd2; end
      OPC_SHR_ZPX: begin mode = AM_ZPX; len = 2'd2; end
      OPC_SHR_ABS: begin mode = AM_ABS; len = 2'd3; end
      OPC_SHR_ABX: begin mode = AM_ABX; len = 2'd3; end
      default:     begin legal = 1'b0; end
    endcase
  end
endmodule

// File: rtl/lsr_shift_unit.sv
module lsr_shift_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         z_out,
  output logic         n_out
);
  assign res   = {1'b0, src[W-1:1]};
  assign c_out = src[0];
  assign z_out = (res == '0);
  assign n_out = res[W-1];
endmodule

// File: rtl/lsr_addr_gen.sv
module lsr_addr_gen
  import lsr_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  amode_e          mode,
  input  logic [AW-1:0]   base,
  input  logic [DW-1:0]   xidx,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   dummy
);
  localparam int HW = AW - DW;

  logic [DW-1:0] lo_sum;
  assign lo_sum = base[DW-1:0] + xidx;

  always_comb begin
    ea    = base;
    dummy = base;
    unique case (mode)
      AM_ZP: begin
        ea    = {{HW{1'b0}}, base[DW-1:0]};
        dummy = ea;
      end
      AM_ZPX: begin
        ea    = {{HW{1'b0}}, lo_sum};
        dummy = {{HW{1'b0}}, base[DW-1:0]};
      end
      AM_ABX: begin
        ea    = base + {{HW{1'b0}}, xidx};
        dummy = {base[AW-1:DW], lo_sum};
      end
      default: begin
        ea    = base;
        dummy = base;
      end
    endcase
  end
endmodule

// File: rtl/lsr_seq_top.sv
module lsr_seq_top
  import lsr_seq_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] PC_RESET = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_opcode,
  input  logic [DATA_W-1:0] in_x,
  input  logic              acc_ld,
  input  logic [DATA_W-1:0] acc_ld_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c
);
  localparam int HW = ADDR_W - DATA_W;

  sstate_e           state_q;
  amode_e            mode_q;
  logic [1:0]        len_q;
  logic [DATA_W-1:0] x_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] acc_q;
  logic [ADDR_W-1:0] pc_q;
  logic              n_q, z_q, c_q, err_q;

  logic              accept;
  logic              dec_legal;
  amode_e            dec_mode;
  logic [1:0]        dec_len;
  logic [ADDR_W-1:0] ea, dummy_addr;
  logic [DATA_W-1:0] sh_src, sh_res;
  logic              sh_c, sh_z, sh_n;

  lsr_decode #(.OPC_W(DATA_W)) u_dec (
    .opcode (in_opcode),
    .legal  (dec_legal),
    .mode   (dec_mode),
    .len    (dec_len)
  );

  lsr_addr_gen #(.AW(ADDR_W), .DW(DATA_W)) u_agen (
    .mode  (mode_q),
    .base  (base_q),
    .xidx  (x_q),
    .ea    (ea),
    .dummy (dummy_addr)
  );

  assign sh_src = (state_q == ST_ACC) ? acc_q : old_q;

  lsr_shift_unit #(.W(DATA_W)) u_shift (
    .src   (sh_src),
    .res   (sh_res),
    .c_out (sh_c),
    .z_out (sh_z),
    .n_out (sh_n)
  );

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign done     = (state_q == ST_ACC) || (state_q == ST_WNEW);
  assign err      = err_q;
  assign acc      = acc_q;
  assign pc       = pc_q;
  assign flag_n   = n_q;
  assign flag_z   = z_q;
  assign flag_c   = c_q;

  // Bus drive per state
  always_comb begin
    mem_addr  = '0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_OPLO: begin mem_re = 1'b1; mem_addr = pc_q + ADDR_W'(1); end
      ST_OPHI: begin mem_re = 1'b1; mem_addr = pc_q + ADDR_W'(2); end
      ST_IDX:  begin mem_re = 1'b1; mem_addr = dummy_addr; end
      ST_RD:   begin mem_re = 1'b1; mem_addr = ea; end
      ST_WOLD: begin mem_we = 1'b1; mem_addr = ea; mem_wdata = old_q; end
      ST_WNEW: begin mem_we = 1'b1; mem_addr = ea; mem_wdata = sh_res; end
      default: ;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= AM_ACC;
      len_q   <= 2'd1;
      x_q     <= '0;
      base_q  <= '0;
      old_q   <= '0;
      acc_q   <= '0;
      pc_q    <= PC_RESET;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
      c_q     <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && !dec_legal;
      unique case (state_q)
        ST_IDLE: begin
          if (acc_ld) acc_q <= acc_ld_data;
          if (accept && dec_legal) begin
            mode_q  <= dec_mode;
            len_q   <= dec_len;
            x_q     <= in_x;
            state_q <= (dec_mode == AM_ACC) ? ST_ACC : ST_OPLO;
          end
        end
        ST_OPLO: begin
          base_q <= {{HW{1'b0}}, mem_rdata};
          if (mode_q == AM_ABS || mode_q == AM_ABX) state_q <= ST_OPHI;
          else if (mode_q == AM_ZPX)                state_q <= ST_IDX;
          else                                      state_q <= ST_RD;
        end
        ST_OPHI: begin
          base_q[ADDR_W-1:DATA_W] <= mem_rdata;
          state_q <= (mode_q == AM_ABX) ? ST_IDX : ST_RD;
        end
        ST_IDX:  state_q <= ST_RD;
        ST_RD: begin
          old_q   <= mem_rdata;
          state_q <= ST_WOLD;
        end
        ST_WOLD: state_q <= ST_WNEW;
        ST_WNEW: begin
          n_q     <= sh_n;
          z_q     <= sh_z;
          c_q     <= sh_c;
          pc_q    <= pc_q + ADDR_W'(len_q);
          state_q <= ST_IDLE;
        end
        ST_ACC: begin
          acc_q   <= sh_res;
          n_q     <= sh_n;
          z_q     <= sh_z;
          c_q     <= sh_c;
          pc_q    <= pc_q + ADDR_W'(len_q);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1: no bus traffic while the issue port is open
  a_r1_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!mem_re && !mem_we));

  // R7: first write of the read-modify-write repeats the preceding read's address
  a_r7_wold_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WOLD) |-> ($past(mem_re) && mem_addr == $past(mem_addr)));

  // R7: shifted write follows the dummy write at the same address
  a_r7_wnew_after_wold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WNEW) |-> ($past(mem_we) && $stable(mem_addr)));

  // R10: an error pulse comes with a quiet bus and an unmoved pc
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_re && !mem_we && $stable(pc_q) && in_ready));

  // R3: accumulator form steps the pc by one
  a_r3_acc_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_lsr_seq_top.sv
module tb_lsr_seq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [7:0]  in_opcode, in_x;
  logic        acc_ld;
  logic [7:0]  acc_ld_data;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done, err;
  logic [7:0]  acc;
  logic [15:0] pc;
  logic        flag_n, flag_z, flag_c;

  always #5 clk = ~clk;

  lsr_seq_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_x(in_x), .acc_ld(acc_ld), .acc_ld_data(acc_ld_data),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .err(err), .acc(acc), .pc(pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Bench memory
  logic [7:0] mem [int];
  function automatic logic [7:0] rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction
  always @(negedge clk) mem_rdata <= rd(mem_addr);
  always @(posedge clk) if (rst_n && mem_we) mem[int'(mem_addr)] = mem_wdata;

  // Scoreboard of expected bus cycles
  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
    string       tag;
  } bus_item_t;
  bus_item_t exp_q[$];

  task automatic push(input bit we, input logic [15:0] a, input logic [7:0] d,
                      input string tag);
    bus_item_t it;
    it.we = we; it.addr = a; it.data = d; it.tag = tag;
    exp_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && (mem_re || mem_we)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected bus cycle addr", int'(mem_addr), 0);
      end else begin
        bus_item_t it;
        it = exp_q.pop_front();
        chk(mem_we == it.we, it.tag, "bus direction (1=write)", int'(mem_we), int'(it.we));
        chk(mem_addr == it.addr, it.tag, "bus address", int'(mem_addr), int'(it.addr));
        if (it.we)
          chk(mem_wdata == it.data, it.tag, "write data", int'(mem_wdata), int'(it.data));
      end
    end
  end

  // Reference state
  logic [7:0]  acc_m = 8'h00;
  logic [15:0] pc_m  = 16'h0200;
  logic        c_m = 1'b0, z_m = 1'b0;

  task automatic run(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [7:0] x, input logic [7:0] val,
                     input bit preset, input logic [7:0] pre_val, input bit poke_busy);
    int          len, ncyc, cyc;
    bit          legal, memop;
    logic [15:0] ea, dmy;
    logic [7:0]  src, res;
    legal = 1'b1; memop = 1'b1; len = 1; ncyc = 2; ea = 16'h0; dmy = 16'h0;
    case (op)
      8'h4A: begin memop = 1'b0; len = 1; ncyc = 2; end
      8'h46: begin len = 2; ncyc = 5; ea = {8'h00, lo}; end
      8'h56: begin len = 2; ncyc = 6; ea = {8'h00, 8'(lo + x)}; dmy = {8'h00, lo}; end
      8'h4E: begin len = 3; ncyc = 6; ea = {hi, lo}; end
      8'h5E: begin len = 3; ncyc = 7; ea = {hi, lo} + {8'h00, x}; dmy = {hi, 8'(lo + x)}; end
      default: legal = 1'b0;
    endcase
    if (legal && memop) begin
      mem[int'(pc_m + 16'd1)] = lo;
      push(1'b0, pc_m + 16'd1, 8'h00, "R4");
      if (len == 3) begin
        mem[int'(pc_m + 16'd2)] = hi;
        push(1'b0, pc_m + 16'd2, 8'h00, "R4");
      end
      if (op == 8'h56) push(1'b0, dmy, 8'h00, "R5");
      if (op == 8'h5E) push(1'b0, dmy, 8'h00, "R6");
      mem[int'(ea)] = val;
      push(1'b0, ea, 8'h00, (op == 8'h56) ? "R5" : (op == 8'h5E) ? "R6" : "R7");
      push(1'b1, ea, val, "R7");
      push(1'b1, ea, val >> 1, "R7");
    end
    src = memop ? val : (preset ? pre_val : acc_m);
    res = src >> 1;

    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready before issue", int'(in_ready), 1);
    in_valid = 1'b1; in_opcode = op; in_x = x;
    acc_ld = preset; acc_ld_data = pre_val;
    @(negedge clk);
    in_valid = 1'b0; in_opcode = 8'h00;
    acc_ld = poke_busy; acc_ld_data = 8'hEE;
    if (!legal) begin
      if (preset) acc_m = pre_val;
      chk(err == 1'b1, "R10", "err pulse", int'(err), 1);
      chk(in_ready == 1'b1, "R10", "in_ready after bad opcode", int'(in_ready), 1);
      @(negedge clk);
      acc_ld = 1'b0;
      chk(err == 1'b0, "R10", "err cleared", int'(err), 0);
      chk(pc == pc_m, "R10", "pc unchanged", int'(pc), int'(pc_m));
      chk(acc == acc_m, "R10", "acc unchanged", int'(acc), int'(acc_m));
      chk(flag_c == c_m && flag_z == z_m, "R10", "flags unchanged",
          int'({flag_z, flag_c}), int'({z_m, c_m}));
      return;
    end
    chk(in_ready == 1'b0, "R1", "in_ready while busy", int'(in_ready), 0);
    cyc = 2;
    while (!done && cyc < 12) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == ncyc, "R2", "cycle count", cyc, ncyc);
    @(negedge clk);
    acc_ld = 1'b0;
    chk(done == 1'b0, "R2", "done is single cycle", int'(done), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after done", int'(in_ready), 1);
    pc_m = pc_m + 16'(len);
    if (!memop) acc_m = res;
    c_m = src[0]; z_m = (res == 8'h00);
    chk(pc == pc_m, "R3", "pc advance", int'(pc), int'(pc_m));
    chk(acc == acc_m, memop ? "R11" : "R8", "acc", int'(acc), int'(acc_m));
    chk(flag_c == c_m, "R9", "carry", int'(flag_c), int'(c_m));
    chk(flag_z == z_m, "R9", "zero", int'(flag_z), int'(z_m));
    chk(flag_n == 1'b0, "R9", "negative", int'(flag_n), 0);
    if (memop) chk(rd(ea) == res, "R8", "memory result", int'(rd(ea)), int'(res));
    chk(exp_q.size() == 0, "R7", "bus cycles left over", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_opcode = 8'h00; in_x = 8'h00;
    acc_ld = 1'b0; acc_ld_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
    chk(pc == 16'h0200, "R3", "reset pc", int'(pc), 16'h0200);
    chk(acc == 8'h00, "R8", "reset acc", int'(acc), 0);
    chk(!done && !err, "R2", "reset done/err", int'({done, err}), 0);
    chk(!flag_n && !flag_z && !flag_c, "R9", "reset flags",
        int'({flag_n, flag_z, flag_c}), 0);

    // R11: preset in the same cycle as an accumulator issue
    run(8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h81, 1'b0);
    run(8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    run(8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h01, 1'b0);
    // zero page
    run(8'h46, 8'h30, 8'h00, 8'h00, 8'h03, 1'b0, 8'h00, 1'b0);
    // R5: zero page + X wraps within page zero
    run(8'h56, 8'hF0, 8'h00, 8'h20, 8'hFF, 1'b0, 8'h00, 1'b0);
    run(8'h56, 8'h40, 8'h00, 8'h05, 8'h02, 1'b0, 8'h00, 1'b0);
    // absolute, with preset strobe held while busy (R11 ignored)
    run(8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h5A, 1'b0);
    run(8'h4E, 8'h34, 8'h12, 8'h00, 8'h80, 1'b0, 8'h00, 1'b1);
    // R6: absolute + X with and without carry into the high byte
    run(8'h5E, 8'hF0, 8'h12, 8'h20, 8'h01, 1'b0, 8'h00, 1'b1);
    run(8'h5E, 8'h10, 8'h40, 8'h05, 8'hC7, 1'b0, 8'h00, 1'b0);
    // R10: unsupported opcodes
    run(8'h6A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    run(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    run(8'h4A, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'hFE, 1'b0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule